// File: doc/BRIEF.md
# Bad-Block-Skipping Image Loader

This controller copies a contiguous image out of NAND flash into a destination memory. Software, or a boot state machine, gives it a page-aligned flash byte offset, a byte length and a destination base address, then pulses `start`. The loader walks the erase blocks that the range covers. On entering each block it first asks an external command sequencer for the factory bad-block marker of that block. A good block is then copied page by page, and the destination address advances by one page size per page. A bad block is skipped whole. The end of the range then moves out by one block, so the image continues in the next good block and keeps its full length.

Requests go to the sequencer over a simple valid/ready interface. Each accepted request is closed by a one-cycle completion strobe. For marker reads the strobe carries the marker value. Byte-level flash timing, error correction and programming belong to the sequencer or to other blocks.

Top module: `nand_image_loader`

## Requirements
- R1: On an accepted start, the first block visited is offset / (PAGE_BYTES*PAGES_PER_BLK). Before any bad block is found, the last block visited is (offset + length - 1) / (PAGE_BYTES*PAGES_PER_BLK).
- R2: In the first block, page reads begin at page (offset mod block bytes) / PAGE_BYTES. In every later block they begin at page 0.
- R3: Each visited block gets exactly one marker request (req_is_page = 0, req_page = 0) before any page request for that block.
- R4: With BUS16 = 0 a block is bad when cmp_data[7:0] is not 8'hFF, and cmp_data[15:8] has no effect. With BUS16 = 1 a block is bad when cmp_data is not 16'hFFFF.
- R5: A bad block gets no page requests. The last-block bound grows by one and skip_count grows by one. skip_count is cleared by an accepted start.
- R6: A good block gets page requests for every page from its start page to PAGES_PER_BLK-1, in increasing order. req_dst starts at dst_base and advances by PAGE_BYTES after each completed page.
- R7: A start whose offset is not a multiple of PAGE_BYTES, or whose length is zero, sets err and issues no request, and busy stays low. err is cleared by the next accepted start.
- R8: done pulses high for one cycle after the completion of the last page of the last block, and busy falls in that same cycle.
- R9: A request, once raised, holds req_valid and all request fields stable until req_ready is seen.
- R10: After reset, busy, done, err, req_valid and skip_count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load. Only sampled while idle |
| offset | input | ADDR_W | Flash byte offset of the image |
| length | input | ADDR_W | Image length in bytes |
| dst_base | input | DST_W | Destination address of the first page |
| req_valid | output | 1 | Request to the sequencer is pending |
| req_ready | input | 1 | Sequencer accepts the pending request |
| req_is_page | output | 1 | 1 = page read, 0 = bad-block marker read |
| req_block | output | ADDR_W | Erase block number |
| req_page | output | $clog2(PAGES_PER_BLK) | Page within the block (0 for marker reads) |
| req_dst | output | DST_W | Destination address for this page |
| cmp_valid | input | 1 | One-cycle completion of the accepted request |
| cmp_data | input | 16 | Marker value returned with a marker completion |
| busy | output | 1 | A load is in progress |
| done | output | 1 | One-cycle pulse at the end of a load |
| err | output | 1 | Last start was rejected |
| skip_count | output | ADDR_W | Bad blocks skipped in the current or last load |

## Verification
The bench builds the loader with 16-byte pages, four pages per block, 16-bit addresses and an 8-bit device. A block is therefore only 64 bytes, and a sweep over every page-aligned offset in the first three blocks, against lengths that sit just below, at and just above page and block boundaries, stays short. Three bad-block maps are used: no bad blocks, isolated bad blocks, and a run of consecutive bad blocks that includes the start block. Together they reach the extended end bound, skipping in the first block and repeated extension. Bad and good markers carry different upper bytes, which shows that the upper byte is ignored on an 8-bit device.

// File: rtl/nil_pkg.sv
package nil_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_MREQ  = 3'd1,
    S_MWAIT = 3'd2,
    S_PREQ  = 3'd3,
    S_PWAIT = 3'd4
  } walk_state_t;
endpackage

// File: rtl/nil_geom.sv
// Splits a byte range into first block, first page and last block.
module nil_geom #(
  parameter int ADDR_W        = 32,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic [ADDR_W-1:0]                  offset,
  input  logic [ADDR_W-1:0]                  length,
  output logic [ADDR_W-1:0]                  first_blk,
  output logic [ADDR_W-1:0]                  last_blk,
  output logic [$clog2(PAGES_PER_BLK)-1:0]   first_pg,
  output logic                               arg_bad
);
  localparam int PG_SH  = $clog2(PAGE_BYTES);
  localparam int BLK_SH = PG_SH + $clog2(PAGES_PER_BLK);

  logic [ADDR_W:0] end_byte;

  always_comb begin
    end_byte  = {1'b0, offset} + {1'b0, length} - {{ADDR_W{1'b0}}, 1'b1};
    first_blk = offset >> BLK_SH;
    last_blk  = ADDR_W'(end_byte >> BLK_SH);
    first_pg  = offset[BLK_SH-1:PG_SH];
    arg_bad   = (|offset[PG_SH-1:0]) || (length == '0);
  end
endmodule

// File: rtl/nil_marker.sv
// Bad-block decision from the returned spare-area marker.
module nil_marker #(
  parameter bit BUS16 = 1'b0
) (
  input  logic [15:0] marker,
  output logic        is_bad
);
  generate
    if (BUS16) begin : g_wide
      always_comb is_bad = (marker != 16'hFFFF);
    end else begin : g_narrow
      logic [7:0] hi_unused;
      always_comb begin
        hi_unused = marker[15:8] & 8'h00;
        is_bad    = (marker[7:0] != 8'hFF) | (|hi_unused);
      end
    end
  endgenerate
endmodule

// File: rtl/nil_walker.sv
// Block/page walk state machine with bound extension on bad blocks.
module nil_walker
  import nil_pkg::*;
#(
  parameter int ADDR_W        = 32,
  parameter int DST_W         = 32,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic                             arg_bad,
  input  logic [ADDR_W-1:0]                first_blk,
  input  logic [ADDR_W-1:0]                last_blk,
  input  logic [$clog2(PAGES_PER_BLK)-1:0] first_pg,
  input  logic [DST_W-1:0]                 dst_base,
  input  logic                             req_ready,
  input  logic                             cmp_valid,
  input  logic                             is_bad,
  output logic                             req_valid,
  output logic                             req_is_page,
  output logic [ADDR_W-1:0]                req_block,
  output logic [$clog2(PAGES_PER_BLK)-1:0] req_page,
  output logic [DST_W-1:0]                 req_dst,
  output logic                             busy,
  output logic                             done,
  output logic                             err,
  output logic [ADDR_W-1:0]                skip_count
);
  localparam int PG_W = $clog2(PAGES_PER_BLK);
  localparam logic [PG_W-1:0]  LAST_PG  = PG_W'(PAGES_PER_BLK - 1);
  localparam logic [DST_W-1:0] DST_STEP = DST_W'(PAGE_BYTES);

  walk_state_t       state;
  logic [ADDR_W-1:0] blk, bound, skips;
  logic [PG_W-1:0]   pg;
  logic [DST_W-1:0]  dst;
  logic              done_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= S_IDLE;
      blk    <= '0;
      bound  <= '0;
      skips  <= '0;
      pg     <= '0;
      dst    <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (arg_bad) begin
            err_q <= 1'b1;
          end else begin
            err_q <= 1'b0;
            blk   <= first_blk;
            bound <= last_blk;
            pg    <= first_pg;
            dst   <= dst_base;
            skips <= '0;
            state <= S_MREQ;
          end
        end
        S_MREQ: if (req_ready) state <= S_MWAIT;
        S_MWAIT: if (cmp_valid) begin
          if (is_bad) begin
            skips <= skips + 1'b1;
            bound <= bound + 1'b1;
            blk   <= blk + 1'b1;
            pg    <= '0;
            state <= S_MREQ;
          end else begin
            state <= S_PREQ;
          end
        end
        S_PREQ: if (req_ready) state <= S_PWAIT;
        S_PWAIT: if (cmp_valid) begin
          dst <= dst + DST_STEP;
          if (pg == LAST_PG) begin
            pg  <= '0;
            blk <= blk + 1'b1;
            if (blk >= bound) begin
              state  <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              state <= S_MREQ;
            end
          end else begin
            pg    <= pg + 1'b1;
            state <= S_PREQ;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid   = (state == S_MREQ) || (state == S_PREQ);
    req_is_page = (state == S_PREQ) || (state == S_PWAIT);
    req_block   = blk;
    req_page    = req_is_page ? pg : '0;
    req_dst     = dst;
    busy        = (state != S_IDLE);
    done        = done_q;
    err         = err_q;
    skip_count  = skips;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_is_page) &&
      $stable(req_block) && $stable(req_page) && $stable(req_dst));
  // R3
  marker_page_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_is_page |-> req_page == '0);
  // R5
  skip_step_chk: assert property (@(posedge clk) disable iff (rst)
    skip_count > $past(skip_count) |-> $past(cmp_valid && is_bad));
  // R6
  dst_step_chk: assert property (@(posedge clk) disable iff (rst)
    $past(busy) && req_dst != $past(req_dst) |-> req_dst == $past(req_dst) + DST_STEP);
  // R7
  err_idle_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> !busy);
  // R8
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy && $past(busy));
endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader #(
  parameter int ADDR_W        = 32,
  parameter int DST_W         = 32,
  parameter int PAGE_BYTES    = 2048,
  parameter int PAGES_PER_BLK = 64,
  parameter bit BUS16         = 1'b0
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             start,
  input  logic [ADDR_W-1:0]                offset,
  input  logic [ADDR_W-1:0]                length,
  input  logic [DST_W-1:0]                 dst_base,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic                             req_is_page,
  output logic [ADDR_W-1:0]                req_block,
  output logic [$clog2(PAGES_PER_BLK)-1:0] req_page,
  output logic [DST_W-1:0]                 req_dst,
  input  logic                             cmp_valid,
  input  logic [15:0]                      cmp_data,
  output logic                             busy,
  output logic                             done,
  output logic                             err,
  output logic [ADDR_W-1:0]                skip_count
);
  localparam int PG_W = $clog2(PAGES_PER_BLK);

  logic [ADDR_W-1:0] first_blk, last_blk;
  logic [PG_W-1:0]   first_pg;
  logic              arg_bad, is_bad;

  nil_geom #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .PAGES_PER_BLK(PAGES_PER_BLK)) geom_i (
    .offset(offset), .length(length), .first_blk(first_blk),
    .last_blk(last_blk), .first_pg(first_pg), .arg_bad(arg_bad));

  nil_marker #(.BUS16(BUS16)) marker_i (.marker(cmp_data), .is_bad(is_bad));

  nil_walker #(.ADDR_W(ADDR_W), .DST_W(DST_W), .PAGE_BYTES(PAGE_BYTES),
               .PAGES_PER_BLK(PAGES_PER_BLK)) walker_i (
    .clk(clk), .rst(rst), .start(start), .arg_bad(arg_bad),
    .first_blk(first_blk), .last_blk(last_blk), .first_pg(first_pg),
    .dst_base(dst_base), .req_ready(req_ready), .cmp_valid(cmp_valid),
    .is_bad(is_bad), .req_valid(req_valid), .req_is_page(req_is_page),
    .req_block(req_block), .req_page(req_page), .req_dst(req_dst),
    .busy(busy), .done(done), .err(err), .skip_count(skip_count));
endmodule

// File: tb/nand_image_loader_tb.sv
`timescale 1ns/1ps
module nand_image_loader_tb_top;
  localparam int AW = 16, DW = 16, PB = 16, PPB = 4, BLKB = PB * PPB;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [AW-1:0] offset = '0, length = '0;
  logic [DW-1:0] dst_base = '0;
  logic req_valid, req_ready = 1'b0, req_is_page;
  logic [AW-1:0] req_block;
  logic [1:0] req_page;
  logic [DW-1:0] req_dst;
  logic cmp_valid = 1'b0;
  logic [15:0] cmp_data = '0;
  logic busy, done, err;
  logic [AW-1:0] skip_count;

  always #2.5 clk = ~clk;

  nand_image_loader #(.ADDR_W(AW), .DST_W(DW), .PAGE_BYTES(PB),
                      .PAGES_PER_BLK(PPB), .BUS16(1'b0)) dut_i (.*);

  int n_chk = 0, n_bad = 0;
  logic [63:0] badmap = '0;

  int rec_n = 0;
  logic rec_kind [0:255];
  int   rec_blk  [0:255];
  int   rec_pg   [0:255];
  int   rec_dst  [0:255];

  int exp_n, exp_skip;
  logic exp_kind [0:255];
  int   exp_blk  [0:255];
  int   exp_pg   [0:255];
  int   exp_dst  [0:255];

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sequencer model: grants a request for one cycle, then completes after a short latency.
  initial begin
    int phase = 0, lat = 0;
    forever begin
      @(negedge clk);
      if (phase == 0) begin
        if (req_valid && rec_n < 256) begin
          rec_kind[rec_n] = req_is_page;
          rec_blk[rec_n]  = int'(req_block);
          rec_pg[rec_n]   = int'(req_page);
          rec_dst[rec_n]  = int'(req_dst);
          // R4: bad markers keep a high upper byte, good ones a non-FF upper byte
          if (!req_is_page)
            cmp_data = badmap[req_block[5:0]] ? ((rec_n % 2) ? 16'hFF00 : 16'hFFFE) : 16'h12FF;
          else
            cmp_data = 16'h0000;
          lat = rec_n % 3;
          rec_n++;
          req_ready = 1'b1;
          phase = 1;
        end
      end else if (phase == 1) begin
        req_ready = 1'b0;
        if (lat == 0) begin cmp_valid = 1'b1; phase = 2; end
        else lat--;
      end else begin
        cmp_valid = 1'b0;
        phase = 0;
      end
    end
  end

  task automatic build_expect(input int off, input int len, input int base);
    int blk, last, pg, dst;
    blk = off / BLKB; last = (off + len - 1) / BLKB;
    pg = (off % BLKB) / PB; dst = base;
    exp_n = 0; exp_skip = 0;
    while (blk <= last) begin
      exp_kind[exp_n] = 1'b0; exp_blk[exp_n] = blk; exp_pg[exp_n] = 0; exp_dst[exp_n] = dst;
      exp_n++;
      if (badmap[blk]) begin
        last++; exp_skip++;
      end else begin
        while (pg < PPB) begin
          exp_kind[exp_n] = 1'b1; exp_blk[exp_n] = blk; exp_pg[exp_n] = pg; exp_dst[exp_n] = dst;
          exp_n++; dst += PB; pg++;
        end
      end
      pg = 0; blk++;
    end
  endtask

  task automatic run_case(input int off, input int len, input int base);
    int guard;
    build_expect(off, len, base);
    rec_n = 0;
    @(negedge clk);
    offset = AW'(off); length = AW'(len); dst_base = DW'(base); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    guard = 0;
    while (!done && guard < 3000) begin @(negedge clk); guard++; end
    check("R8 done pulse seen", longint'(done), 1);
    check("R8 busy low with done", longint'(busy), 0);
    check("R7 err clear after good start", longint'(err), 0);
    check("R1 request count", rec_n, exp_n);
    check("R5 skip_count", longint'(skip_count), exp_skip);
    for (int i = 0; i < exp_n && i < rec_n; i++) begin
      check("R3 request kind", longint'(rec_kind[i]), longint'(exp_kind[i]));
      check("R1 block", rec_blk[i], exp_blk[i]);
      check("R2 page", rec_pg[i], exp_pg[i]);
      if (exp_kind[i]) check("R6 dst", rec_dst[i], exp_dst[i]);
    end
    @(negedge clk);
    check("R8 done one cycle", longint'(done), 0);
  endtask

  task automatic reject_case(input int off, input int len);
    rec_n = 0;
    @(negedge clk);
    offset = AW'(off); length = AW'(len); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (6) @(negedge clk);
    check("R7 err set", longint'(err), 1);
    check("R7 not busy", longint'(busy), 0);
    check("R7 no requests", rec_n, 0);
  endtask

  initial begin
    int lens [10] = '{1, 15, 16, 17, 40, 64, 65, 100, 128, 191};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    check("R10 busy", longint'(busy), 0);
    check("R10 done", longint'(done), 0);
    check("R10 err", longint'(err), 0);
    check("R10 req_valid", longint'(req_valid), 0);
    check("R10 skip_count", longint'(skip_count), 0);

    reject_case(5, 16);   // R7 misaligned
    reject_case(16, 0);   // R7 zero length
    reject_case(40, 3);   // R7 misaligned inside page

    for (int pat = 0; pat < 3; pat++) begin
      badmap = '0;
      if (pat == 1) begin badmap[1] = 1'b1; badmap[4] = 1'b1; end
      if (pat == 2) begin badmap[0] = 1'b1; badmap[2] = 1'b1; badmap[3] = 1'b1; end
      for (int p = 0; p < 12; p++)
        for (int li = 0; li < 10; li++)
          run_case(p * PB, lens[li], 16'h1000 + p * 3);
    end
    reject_case(3, 8);    // R7 err returns after a valid load
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule